// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host port and an asynchronous static RAM. It takes one read or one write request at a time. It drives the memory's chip enable, output enable and write enable in a safe order, and it holds the address steady for the whole access. Each timing interval is a parameter, counted in clock cycles. A write passes through four phases: address setup, write pulse with data valid, data hold and recovery. The recovery phase is lengthened when needed so that the total cycle meets the minimum write cycle time. A read holds chip enable and output enable active for the longer of the access delay and the minimum read cycle. It captures the memory data on the last clock of that window.

The host raises `req_i` with `we_i`, `addr_i` and `wdata_i`. The request is only taken while `busy_o` is low. When the access ends, the controller raises `done_o` for one cycle. For a read, `rdata_o` is already valid in that cycle. The memory data bus is split into an output bus with an enable and an input bus. Any tristate pad sits outside this block. All interval parameters must be at least 1.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request, `mem_ce_no`, `mem_oe_no` and `mem_we_no` are 1, `mem_dq_oe_o`, `busy_o` and `done_o` are 0.
- R2: While `mem_ce_no` is 0, `mem_addr_o` equals the address taken with the request and does not change, even if `addr_i` changes.
- R3: In a write, `mem_ce_no` goes low first and `mem_we_no` stays 1 for exactly T_AS cycles before it falls.
- R4: `mem_we_no` stays 0 for exactly T_DW cycles, and during all of them `mem_dq_oe_o` is 1 with `mem_dq_o` equal to the request data.
- R5: After `mem_we_no` returns to 1, `mem_dq_oe_o` stays 1 for exactly T_DH cycles and then drops to 0.
- R6: A write keeps `mem_ce_no` at 0 for max(T_WC, T_AS+T_DW+T_DH+T_WR) cycles in a row. The last T_WR or more of those cycles have no strobe other than chip enable active.
- R7: A read keeps `mem_ce_no` and `mem_oe_no` at 0 for max(T_RC, T_ACC) cycles in a row. `rdata_o` holds the memory input sampled on the last of these cycles.
- R8: `busy_o` is 1 from the cycle after a request is taken until `done_o` has been high. `done_o` is high for exactly one cycle, the cycle right after `mem_ce_no` returns to 1. The controller is idle in the following cycle.
- R9: `mem_we_no` and `mem_oe_no` are never 0 in the same cycle. `mem_dq_oe_o` is 0 throughout a read.
- R10: A request raised while `busy_o` is 1 is ignored. It starts no memory cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| mem_addr_o | output | AW | Memory address bus |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_dq_o | output | DW | Data driven to memory |
| mem_dq_oe_o | output | 1 | Enable for the data driver |
| mem_dq_i | input | DW | Data from memory |

## Verification
The bench uses a write cycle whose phase sum is shorter than T_WC, and a read whose access delay is longer than T_RC. It then checks every strobe on every cycle of each access against offsets computed from the parameters. A design that skipped the stretch would release chip enable early. A design that sized the read by T_RC alone would capture the filler value that the memory model returns before the access delay has passed. A design that dropped the data driver together with write enable would store garbage, and the full write-then-read sweep would expose it. A request pulsed in the middle of a write, with a different address, would change the address mid-cycle or start an extra cycle in a design that does not gate requests with busy.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_WRECOV, ST_RACC, ST_DONE
  } seq_st_e;

  function automatic int max_i(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int T_AS  = 1,
  parameter int T_DW  = 2,
  parameter int T_DH  = 1,
  parameter int T_WR  = 1,
  parameter int T_ACC = 3,
  parameter int T_WC  = 7,
  parameter int T_RC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int W_SUM   = T_AS + T_DW + T_DH + T_WR;
  localparam int W_PAD   = max_i(T_WC - W_SUM, 0);
  localparam int T_REC   = T_WR + W_PAD;          // recovery absorbs the stretch
  localparam int R_LEN   = max_i(T_ACC, T_RC);
  localparam int MAX_LEN = max_i(max_i(max_i(T_AS, T_DW), max_i(T_DH, T_REC)), R_LEN);
  localparam int CW      = $clog2(MAX_LEN + 1);

  seq_st_e       st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          load;
  logic [CW-1:0] load_val;
  logic          cnt_zero;
  logic          take;

  assign take = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    load_val = '0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        load = 1'b1;
        if (we_i) begin st_d = ST_WSETUP; load_val = CW'(T_AS - 1); end
        else      begin st_d = ST_RACC;   load_val = CW'(R_LEN - 1); end
      end
      ST_WSETUP: if (cnt_zero) begin st_d = ST_WPULSE; load = 1'b1; load_val = CW'(T_DW - 1); end
      ST_WPULSE: if (cnt_zero) begin st_d = ST_WHOLD;  load = 1'b1; load_val = CW'(T_DH - 1); end
      ST_WHOLD:  if (cnt_zero) begin st_d = ST_WRECOV; load = 1'b1; load_val = CW'(T_REC - 1); end
      ST_WRECOV: if (cnt_zero) st_d = ST_DONE;
      ST_RACC:   if (cnt_zero) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end

  sram_phase_cnt #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (cnt_zero)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i ((st_q == ST_RACC) && cnt_zero),
    .d_i   (mem_dq_i),
    .q_o   (rdata_o)
  );

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_ce_no   = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign mem_oe_no   = (st_q != ST_RACC);
  assign mem_we_no   = (st_q != ST_WPULSE);
  assign mem_dq_oe_o = (st_q == ST_WPULSE) || (st_q == ST_WHOLD);
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ce_no,
  input logic          mem_oe_no,
  input logic          mem_we_no,
  input logic          mem_dq_oe_o
);
  assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));

  assert_setup_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> mem_we_no);

  assert_data_in_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_dq_oe_o);

  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_no == 1'b0 && mem_oe_no == 1'b0));

  assert_no_drive_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);

  assert_start_from_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> $past(!busy_o));
endmodule

bind sram_seq_ctrl sram_seq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_addr_o (mem_addr_o),
  .mem_ce_no  (mem_ce_no),
  .mem_oe_no  (mem_oe_no),
  .mem_we_no  (mem_we_no),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sim_sram_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sram_seq_ctrl;
  localparam int AW = 4, DW = 8;
  localparam int T_AS = 1, T_DW = 2, T_DH = 1, T_WR = 1;
  localparam int T_ACC = 3, T_WC = 7, T_RC = 2;
  localparam int WSUM = T_AS + T_DW + T_DH + T_WR;
  localparam int WLEN = (T_WC > WSUM) ? T_WC : WSUM;
  localparam int RLEN = (T_ACC > T_RC) ? T_ACC : T_RC;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, ce_n, oe_n, we_n, dq_oe;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [AW-1:0] maddr;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_DW(T_DW), .T_DH(T_DH),
    .T_WR(T_WR), .T_ACC(T_ACC), .T_WC(T_WC), .T_RC(T_RC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i));

  // memory model: data valid only after T_ACC cycles of output enable
  logic [DW-1:0] mem [1<<AW];
  int oe_run = 0;
  logic we_prev = 1'b1;
  always @(posedge clk) oe_run <= oe_n ? 0 : oe_run + 1;
  assign dq_i = (!oe_n && !ce_n && oe_run >= T_ACC - 1) ? mem[maddr] : 8'hEE;
  always @(negedge clk) begin
    if (!we_prev && we_n && !ce_n) mem[maddr] <= dq_oe ? dq_o : 8'h55;
    we_prev <= we_n;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit intrude);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; addr = ~a; wdata = ~d;
    for (int k = 0; k < WLEN; k++) begin
      if (intrude && k == 2) begin req = 1; we = 1; addr = a ^ 4'h1; wdata = 8'hA5; end
      if (intrude && k == 3) req = 0;
      check("R6 ce low in write", ce_n, 0);
      check("R2 addr held", maddr, a);
      check("R3/R4 we strobe", we_n, (k >= T_AS && k < T_AS + T_DW) ? 0 : 1);
      check("R5 driver window", dq_oe, (k >= T_AS && k < T_AS + T_DW + T_DH) ? 1 : 0);
      if (dq_oe) check("R4 write data", dq_o, d);
      check("R9 oe off in write", oe_n, 1);
      check("R8 busy in write", busy, 1);
      check("R8 no early done", done, 0);
      @(negedge clk);
    end
    check("R6 ce released", ce_n, 1);
    check("R8 done after write", done, 1);
    @(negedge clk);
    check("R8 idle after done", busy, 0);
    check("R8 done one cycle", done, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; addr = ~a;
    for (int k = 0; k < RLEN; k++) begin
      check("R7 ce low in read", ce_n, 0);
      check("R7 oe low in read", oe_n, 0);
      check("R9 we off in read", we_n, 1);
      check("R9 no drive in read", dq_oe, 0);
      check("R2 addr held read", maddr, a);
      @(negedge clk);
    end
    check("R7 strobes released", {ce_n, oe_n}, 2'b11);
    check("R8 done after read", done, 1);
    check("R7 read data", rdata, exp_d);
    @(negedge clk);
    check("R8 idle after read", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    #1;
    check("R1 reset ce", ce_n, 1);
    check("R1 reset strobes", {oe_n, we_n, dq_oe}, 3'b110);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 idle busy/done", {busy, done}, 2'b00);
    check("R1 idle ce", ce_n, 1);

    for (int a = 0; a < (1 << AW); a++) do_write(AW'(a), pat(a), 0);
    for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), pat(a));

    // R10: request pulsed mid-write with another address
    do_write(4'h5, 8'h3C, 1);
    for (int k = 0; k < 3; k++) begin
      check("R10 no extra cycle", ce_n, 1);
      check("R10 stays idle", busy, 0);
      @(negedge clk);
    end
    do_read(4'h5, 8'h3C);
    do_read(4'h4, pat(4));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule